// File: doc/BRIEF.md
# Carry-Select Adder with Growing Block Sizes

This block adds two unsigned operands and an incoming carry. It splits the operand bits into consecutive blocks. The lowest block is a plain ripple adder. Every higher block computes its result twice in parallel: one copy assumes the carry arriving from below is 0, the other assumes it is 1. Once the real carry leaves the block beneath, a multiplexer picks the matching copy. That chosen carry then steers the next block's multiplexer.

A parameter selects one of two partitions:

- **Uniform:** four equal 4-bit blocks, for 16 bits.
- **Growing:** blocks of 2, 3, 4 and 5 bits, for 14 bits. Each block is one bit longer than the one below it, so the slow upper rippling overlaps the carry's trip through the lower blocks.

Operand width follows from the partition. For FPGA timing closure, the sum and the final carry are registered on the rising clock edge. A synchronous active-high reset clears that register.

Top module: `csa_adder`

## Requirements
- R1: One clock after operands `a_i`, `b_i` and carry `cin_i` are applied, `{cout_o, sum_o}` equals the full unsigned value a + b + cin, with no truncation.
- R2: When `rst` is high at a rising edge, `sum_o` and `cout_o` become 0 on that edge, whatever the operand values.
- R3: With `SQRT_MODE` = 0, the operand width is 16 and the blocks cover bits [3:0], [7:4], [11:8] and [15:12].
- R4: With `SQRT_MODE` = 1, the operand width is 14 and the blocks cover bits [1:0], [4:2], [8:5] and [13:9].
- R5: A carry-in of 1 with `a_i` all ones and `b_i` zero passes through every block: the sum is 0 and the carry-out is 1.
- R6: The carry leaving each block equals the carry into that bit position of the exact sum of the lower bits. This holds whether the carry was generated inside the block or passed through it.
- R7: Each non-first block precomputes both candidate results, and the carry from the block below selects between them. Upper operand bits that are left unchanged therefore give a different upper sum when only the incoming carry flips.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; output register updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the output register |
| a_i | input | W | First operand (W = 16 uniform, 14 growing) |
| b_i | input | W | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | W | Registered sum |
| cout_o | output | 1 | Registered carry out of the top bit |

## Verification
The bench targets carries that cross each block boundary of both partitions.

- **Boundary carries:** runs of ones end exactly at a boundary, and a single generate sits on the top bit of a block. A multiplexer wired to the wrong block's carry, or to a fixed value, shows up as a sum off by a power of two at that boundary.
- **Full-width propagation:** a carry-in travels through an all-ones operand. This exposes a break anywhere in the chain as a nonzero sum or a lost carry-out.
- **Swapped candidates:** pairs that differ only in the incoming carry catch a block whose two precomputed copies are exchanged.
- **Reset:** reset applied with busy operands catches a register that does not clear.

// File: rtl/csa_pkg.sv
package csa_pkg;

  // Lowest bit index of block k when block 0 has first_w bits and each
  // later block is step bits wider than its predecessor.
  function automatic int blk_lo(input int k, input int first_w, input int step);
    return k * first_w + (step * k * (k - 1)) / 2;
  endfunction

  // Width of block k.
  function automatic int blk_w(input int k, input int first_w, input int step);
    return first_w + step * k;
  endfunction

  // Total operand width covered by nblk blocks.
  function automatic int total_w(input int nblk, input int first_w, input int step);
    return blk_lo(nblk, first_w, step);
  endfunction

endpackage

// File: rtl/csa_pg_setup.sv
// Per-bit setup stage: half-sum (propagate) and carry-generate terms.
module csa_pg_setup #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] p,
  output logic [W-1:0] g
);
  assign p = a ^ b;
  assign g = a & b;
endmodule

// File: rtl/csa_ripple.sv
// Ripple carry chain over precomputed propagate/generate terms.
module csa_ripple #(
  parameter int W = 4
) (
  input  logic [W-1:0] p,
  input  logic [W-1:0] g,
  input  logic         cin,
  output logic [W-1:0] s,
  output logic         cout
);
  logic [W:0] c;

  assign c[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign c[i+1] = g[i] | (p[i] & c[i]);
    assign s[i]   = p[i] ^ c[i];
  end

  assign cout = c[W];
endmodule

// File: rtl/csa_select_block.sv
// One upper block: two speculative ripple chains sharing a setup stage,
// resolved by the real incoming carry.
module csa_select_block #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         csel,
  output logic [W-1:0] s,
  output logic         cout
);
  logic [W-1:0] p;
  logic [W-1:0] g;
  logic [W-1:0] s_if0;
  logic [W-1:0] s_if1;
  logic         c_if0;
  logic         c_if1;

  csa_pg_setup #(.W(W)) setup_i (
    .a (a),
    .b (b),
    .p (p),
    .g (g)
  );

  csa_ripple #(.W(W)) chain0_i (
    .p    (p),
    .g    (g),
    .cin  (1'b0),
    .s    (s_if0),
    .cout (c_if0)
  );

  csa_ripple #(.W(W)) chain1_i (
    .p    (p),
    .g    (g),
    .cin  (1'b1),
    .s    (s_if1),
    .cout (c_if1)
  );

  assign s    = csel ? s_if1 : s_if0;
  assign cout = csel ? c_if1 : c_if0;
endmodule

// File: rtl/csa_adder.sv
module csa_adder
  import csa_pkg::*;
#(
  parameter bit SQRT_MODE = 1'b1,
  parameter int NBLK      = 4,
  parameter int FIRST_W   = SQRT_MODE ? 2 : 4,
  parameter int STEP      = SQRT_MODE ? 1 : 0,
  localparam int W        = total_w(NBLK, FIRST_W, STEP)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);

  // blk_c[k] is the resolved carry entering block k; blk_c[NBLK] leaves the top.
  logic [NBLK:0] blk_c;
  logic [W-1:0]  sum_c;

  assign blk_c[0] = cin_i;

  for (genvar k = 0; k < NBLK; k++) begin : g_blk
    localparam int LO = blk_lo(k, FIRST_W, STEP);
    localparam int BW = blk_w(k, FIRST_W, STEP);

    if (k == 0) begin : g_first
      logic [BW-1:0] p0;
      logic [BW-1:0] g0;

      csa_pg_setup #(.W(BW)) setup_i (
        .a (a_i[LO+BW-1:LO]),
        .b (b_i[LO+BW-1:LO]),
        .p (p0),
        .g (g0)
      );

      csa_ripple #(.W(BW)) chain_i (
        .p    (p0),
        .g    (g0),
        .cin  (blk_c[k]),
        .s    (sum_c[LO+BW-1:LO]),
        .cout (blk_c[k+1])
      );
    end else begin : g_sel
      csa_select_block #(.W(BW)) sel_i (
        .a    (a_i[LO+BW-1:LO]),
        .b    (b_i[LO+BW-1:LO]),
        .csel (blk_c[k]),
        .s    (sum_c[LO+BW-1:LO]),
        .cout (blk_c[k+1])
      );
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_o  <= '0;
      cout_o <= 1'b0;
    end else begin
      sum_o  <= sum_c;
      cout_o <= blk_c[NBLK];
    end
  end

endmodule

// File: rtl/csa_adder_chk.sv
module csa_adder_chk
  import csa_pkg::*;
#(
  parameter int W       = 14,
  parameter int NBLK    = 4,
  parameter int FIRST_W = 2,
  parameter int STEP    = 1
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic         cin_i,
  input logic [W-1:0] sum_o,
  input logic         cout_o,
  input logic [NBLK:0] blk_c
);

  logic started = 1'b0;
  always_ff @(posedge clk) started <= 1'b1;

  logic [W:0] ref_full;
  assign ref_full = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};

  // R1: registered result equals the exact sum of the previous cycle's inputs
  assert_sum_matches_R1: assert property (@(posedge clk) disable iff (rst)
    (started && !$past(rst)) |-> ({cout_o, sum_o} == $past(ref_full)));

  // R2: reset clears the outputs
  assert_reset_clears_R2: assert property (@(posedge clk)
    (started && $past(rst)) |-> (sum_o == '0 && !cout_o));

  // R5: registered carry-out follows the carry resolved out of the top block
  assert_cout_follows_R5: assert property (@(posedge clk) disable iff (rst)
    started |=> (cout_o == $past(blk_c[NBLK])));

  // R6 / R7: each selected block carry matches the exact carry of the lower bits
  for (genvar k = 1; k <= NBLK; k++) begin : g_bc
    localparam int LO = blk_lo(k, FIRST_W, STEP);
    logic [LO:0] low_ref;
    assign low_ref = {1'b0, a_i[LO-1:0]} + {1'b0, b_i[LO-1:0]} + {{LO{1'b0}}, cin_i};

    assert_block_carry_R6: assert property (@(posedge clk) disable iff (rst)
      started |-> (blk_c[k] == low_ref[LO]));
  end

endmodule

bind csa_adder csa_adder_chk #(
  .W       (W),
  .NBLK    (NBLK),
  .FIRST_W (FIRST_W),
  .STEP    (STEP)
) chk_i (
  .clk    (clk),
  .rst    (rst),
  .a_i    (a_i),
  .b_i    (b_i),
  .cin_i  (cin_i),
  .sum_o  (sum_o),
  .cout_o (cout_o),
  .blk_c  (blk_c)
);

// File: tb/csa_adder_tb.sv
module csa_adder_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;

  // {a[15:0], b[15:0], cin}
  localparam logic [32:0] VEC [NVEC] = '{
    {16'h0000, 16'h0000, 1'b0},
    {16'hFFFF, 16'h0001, 1'b0},
    {16'hFFFF, 16'hFFFF, 1'b1},
    {16'h8000, 16'h8000, 1'b0},
    {16'h1234, 16'h4321, 1'b0},
    {16'h00FF, 16'h0001, 1'b0},
    {16'h0F0F, 16'hF0F0, 1'b1},
    {16'hAAAA, 16'h5555, 1'b1},
    {16'h0001, 16'hFFFF, 1'b0},
    {16'h7FFF, 16'h0001, 1'b0},
    {16'h3FFF, 16'h0000, 1'b1},
    {16'h1FF0, 16'h0010, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] a16 = '0;
  logic [15:0] b16 = '0;
  logic        cin = 1'b0;

  logic [15:0] sum_l;
  logic        cout_l;
  logic [13:0] sum_s;
  logic        cout_s;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  csa_adder #(.SQRT_MODE(1'b0)) dut_lin_i (
    .clk    (clk),
    .rst    (rst),
    .a_i    (a16),
    .b_i    (b16),
    .cin_i  (cin),
    .sum_o  (sum_l),
    .cout_o (cout_l)
  );

  csa_adder #(.SQRT_MODE(1'b1)) dut_i (
    .clk    (clk),
    .rst    (rst),
    .a_i    (a16[13:0]),
    .b_i    (b16[13:0]),
    .cin_i  (cin),
    .sum_o  (sum_s),
    .cout_o (cout_s)
  );

  task automatic check_val(input string req, input logic [16:0] act, input logic [16:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at the falling edge, register on the next rising edge,
  // compare at the following falling edge.
  task automatic run_vec(input logic [15:0] a, input logic [15:0] b, input logic c,
                         input string tag);
    logic [16:0] exp_l;
    logic [16:0] exp_s;
    a16 = a;
    b16 = b;
    cin = c;
    @(negedge clk);
    exp_l = {1'b0, a} + {1'b0, b} + {16'd0, c};
    exp_s = {3'b0, a[13:0]} + {3'b0, b[13:0]} + {16'd0, c};
    check_val({tag, "/R3 uniform"}, {cout_l, sum_l}, exp_l);
    check_val({tag, "/R4 growing"}, {2'b00, cout_s, sum_s}, exp_s);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lin_bnd [3] = '{4, 8, 12};
    int sq_bnd  [3] = '{2, 5, 9};
    int bnd;
    logic [15:0] mask;

    // R2: reset state
    a16 = 16'hBEEF;
    b16 = 16'h1357;
    cin = 1'b1;
    repeat (2) @(negedge clk);
    check_val("R2 reset uniform", {cout_l, sum_l}, 17'd0);
    check_val("R2 reset growing", {2'b00, cout_s, sum_s}, 17'd0);
    rst = 1'b0;

    // R1: table walk
    for (int i = 0; i < NVEC; i++)
      run_vec(VEC[i][32:17], VEC[i][16:1], VEC[i][0], "R1 table");

    // R5: carry-in through every block
    run_vec(16'hFFFF, 16'h0000, 1'b1, "R5 full propagate");

    // R6 and R7 at every block boundary of both partitions
    for (int j = 0; j < 6; j++) begin
      bnd  = (j < 3) ? lin_bnd[j] : sq_bnd[j-3];
      mask = 16'((32'd1 << bnd) - 1);
      run_vec(mask, 16'h0000, 1'b1, "R6 propagate into boundary");
      run_vec(16'(32'd1 << (bnd - 1)), 16'(32'd1 << (bnd - 1)), 1'b0, "R6 generate at boundary");
      run_vec((16'hA5A5 & ~mask) | mask, 16'h3C3C & ~mask, 1'b0, "R7 select low");
      run_vec((16'hA5A5 & ~mask) | mask, 16'h3C3C & ~mask, 1'b1, "R7 select high");
    end

    // R1: exhaustive low-bit sweep, upper bits of b clear or all ones
    for (int up = 0; up < 2; up++)
      for (int ai = 0; ai < 32; ai++)
        for (int bi = 0; bi < 32; bi++)
          for (int c = 0; c < 2; c++)
            run_vec(16'(ai), (up != 0) ? (16'hFFE0 | 16'(bi)) : 16'(bi), c[0], "R1 sweep");

    // R1: random vectors
    for (int r = 0; r < 1500; r++)
      run_vec(16'($urandom), 16'($urandom), 1'($urandom), "R1 random");

    // R2: reset mid-run with busy operands, then recovery
    a16 = 16'hFFFF;
    b16 = 16'hFFFF;
    cin = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    check_val("R2 mid-run reset uniform", {cout_l, sum_l}, 17'd0);
    check_val("R2 mid-run reset growing", {2'b00, cout_s, sum_s}, 17'd0);
    rst = 1'b0;
    run_vec(16'hFFFF, 16'hFFFF, 1'b1, "R2 recovery");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule